// File: doc/BRIEF.md
# Eight-Line Nested Priority Interrupt Controller

The controller gathers eight interrupt request lines and presents a single interrupt signal to a processor. A rising edge on a line records a pending request. A mask bit for each line keeps that line out of arbitration. Among the unmasked pending requests, line 0 always wins and line 7 always loses. The processor answers the interrupt with an acknowledge pulse. The controller then captures a vector made of a programmable 5-bit base and the 3-bit number of the winning line, and marks that line as in service.

While a line is in service, requests on that line and on every lower-priority line are held back. Only a strictly higher-priority request can raise the interrupt output again, so handlers nest by priority. Software closes a level in one of two ways. It can write an end-of-interrupt command that names the level, or one that closes whichever in-service level has the highest priority. As an alternative, an automatic mode leaves the in-service bit clear after each acknowledge. Configuration and commands arrive through a small write-only register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every pending request and every in-service bit. It sets all eight mask bits, turns off automatic end-of-interrupt, zeroes the vector base and the `vector` output, and holds `int_out` low.
- R2: A 0-to-1 transition on `irq_in[i]` latches a pending request for line i. A line that stays high afterwards adds no further request.
- R3: A write to address 0 loads the mask, where bit i set excludes line i from arbitration. A masked line keeps its pending request, and the request is served once the mask bit is cleared.
- R4: Among unmasked pending requests, the line with the lowest index wins.
- R5: `int_out` is high exactly when a winner exists and no in-service bit is set at the winner's level or at a higher-priority level.
- R6: An `ack` pulse while `int_out` is high clears the winner's pending request and sets its in-service bit. It also loads `vector` with base*8 + level, and `vector` keeps that value until the next accepted acknowledge.
- R7: An `ack` pulse while `int_out` is low changes neither `vector`, the pending requests, nor the in-service bits.
- R8: A write to address 1 sets automatic end-of-interrupt from bit 0 and the vector base from bits 7:3.
- R9: With automatic end-of-interrupt on, an accepted acknowledge leaves the winner's in-service bit clear, so an equal or lower-priority request can interrupt at once.
- R10: A write to address 2 with bits 4:3 = 01 clears the in-service bit of the highest-priority level currently in service.
- R11: A write to address 2 with bits 4:3 = 11 clears only the in-service bit of the level given in bits 2:0, and does nothing if that bit is clear. Opcodes 00 and 10 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, line 0 highest priority |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mask, 1 control, 2 end-of-interrupt command |
| cfg_wdata | input | 8 | Write data |
| ack | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector captured by the last accepted acknowledge |

## Verification
The main sweep takes every ordered pair of lines. One line is put in service first and the other line is raised afterwards. This separates strictly-higher, equal and lower priority in the nesting check. Because a second non-specific close must release the remaining level, the sweep also shows which in-service bit a non-specific close picks.

Directed patterns then cover the following cases:
- Specific closes on set and unset levels, and the opcodes that do nothing.
- Masked-but-pending requests, and held-high lines.
- Acknowledges with no interrupt raised.
- Automatic end-of-interrupt.
- A changed vector base.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int IRQ_N = 8;
  localparam int LVL_W = $clog2(IRQ_N);

  typedef logic [IRQ_N-1:0] irq_vec_t;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    CMD_IDLE0   = 2'b00,
    CMD_CLR_TOP = 2'b01,
    CMD_IDLE2   = 2'b10,
    CMD_CLR_LVL = 2'b11
  } eoi_op_e;

  // index of the highest-priority (lowest-numbered) set bit, 0 when none
  function automatic lvl_t top_level(irq_vec_t v);
    lvl_t r;
    r = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (v[i]) r = lvl_t'(i);
    end
    return r;
  endfunction

  function automatic irq_vec_t level_bit(lvl_t l);
    return irq_vec_t'(1) << l;
  endfunction

  function automatic logic [7:0] make_vector(logic [4:0] base, lvl_t l);
    return {base, l};
  endfunction
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import prio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_vec_t irq_in,
  input  irq_vec_t clr_vec,
  output irq_vec_t edge_vec,
  output irq_vec_t req_q
);
  irq_vec_t prev_q;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_line
    assign edge_vec[g] = irq_in[g] & ~prev_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[g] <= irq_in[g];
        req_q[g]  <= 1'b0;
      end else begin
        prev_q[g] <= irq_in[g];
        req_q[g]  <= (req_q[g] & ~clr_vec[g]) | edge_vec[g];
      end
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import prio_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int BASE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  irq_vec_t          isr_q,
  output irq_vec_t          mask_q,
  output logic              aeoi_q,
  output logic [BASE_W-1:0] base_q,
  output logic              eoi_fire,
  output irq_vec_t          eoi_clr
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(2);

  eoi_op_e op;
  lvl_t    cmd_lvl;

  assign op       = eoi_op_e'(wdata[LVL_W+1:LVL_W]);
  assign cmd_lvl  = wdata[LVL_W-1:0];
  assign eoi_fire = we && (addr == A_EOI);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      aeoi_q <= 1'b0;
      base_q <= '0;
    end else if (we) begin
      if (addr == A_MASK) mask_q <= wdata[IRQ_N-1:0];
      if (addr == A_CTRL) begin
        aeoi_q <= wdata[0];
        base_q <= wdata[DATA_W-1 -: BASE_W];
      end
    end
  end

  always_comb begin
    eoi_clr = '0;
    if (eoi_fire) begin
      case (op)
        CMD_CLR_TOP: eoi_clr = (isr_q == '0) ? '0 : level_bit(top_level(isr_q));
        CMD_CLR_LVL: eoi_clr = level_bit(cmd_lvl);
        default:     eoi_clr = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import prio_irq_pkg::*;
(
  input  irq_vec_t req_q,
  input  irq_vec_t mask_q,
  input  irq_vec_t isr_q,
  output logic     int_req,
  output lvl_t     win_lvl,
  output irq_vec_t win_bit
);
  irq_vec_t live;
  lvl_t     svc_lvl;
  logic     any_live;
  logic     any_svc;

  assign live     = req_q & ~mask_q;
  assign any_live = |live;
  assign any_svc  = |isr_q;
  assign win_lvl  = top_level(live);
  assign svc_lvl  = top_level(isr_q);
  assign win_bit  = any_live ? level_bit(win_lvl) : '0;
  assign int_req  = any_live && (!any_svc || (win_lvl < svc_lvl));
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track
  import prio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_vec_t set_vec,
  input  irq_vec_t clr_vec,
  output irq_vec_t isr_q
);
  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= (isr_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IRQ_N-1:0]  irq_in,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              ack,
  output logic              int_out,
  output logic [VEC_W-1:0]  vector
);
  localparam int BASE_W = VEC_W - LVL_W;

  irq_vec_t          req_q, isr_q, mask_q, edge_vec;
  irq_vec_t          win_bit, eoi_clr, req_clr, isr_set;
  logic              aeoi_q, eoi_fire, ack_fire, int_req;
  logic [BASE_W-1:0] base_q;
  lvl_t              win_lvl;
  logic [VEC_W-1:0]  vector_q;

  assign ack_fire = ack && int_req;
  assign req_clr  = ack_fire ? win_bit : '0;
  assign isr_set  = (ack_fire && !aeoi_q) ? win_bit : '0;
  assign int_out  = int_req;
  assign vector   = vector_q;

  irq_req_latch u_req (
    .clk(clk), .rst(rst), .irq_in(irq_in), .clr_vec(req_clr),
    .edge_vec(edge_vec), .req_q(req_q)
  );

  irq_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .isr_q(isr_q), .mask_q(mask_q), .aeoi_q(aeoi_q), .base_q(base_q),
    .eoi_fire(eoi_fire), .eoi_clr(eoi_clr)
  );

  irq_resolver u_res (
    .req_q(req_q), .mask_q(mask_q), .isr_q(isr_q),
    .int_req(int_req), .win_lvl(win_lvl), .win_bit(win_bit)
  );

  irq_isr_track u_isr (
    .clk(clk), .rst(rst), .set_vec(isr_set), .clr_vec(eoi_clr), .isr_q(isr_q)
  );

  always_ff @(posedge clk) begin
    if (rst)           vector_q <= '0;
    else if (ack_fire) vector_q <= {base_q, win_lvl};
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int BASE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              int_out,
  input logic              ack_fire,
  input logic [VEC_W-1:0]  vector,
  input irq_vec_t          req_q,
  input irq_vec_t          isr_q,
  input irq_vec_t          mask_q,
  input logic              aeoi_q,
  input logic [BASE_W-1:0] base_q
);
  // bits at or above the given priority (indices 0..l)
  function automatic irq_vec_t same_or_higher(lvl_t l);
    irq_vec_t m;
    for (int i = 0; i < IRQ_N; i++) m[i] = (i <= int'(l));
    return m;
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (req_q == '0 && isr_q == '0 && mask_q == '1 && !aeoi_q));

  // R5
  nest_block_chk: assert property (@(posedge clk) disable iff (rst)
    int_out |-> ((req_q & ~mask_q) != '0 &&
                 (isr_q & same_or_higher(top_level(req_q & ~mask_q))) == '0));

  // R6
  ack_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && !aeoi_q) |=> isr_q[vector[LVL_W-1:0]]);

  // R6
  vec_base_chk: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> (vector[VEC_W-1 -: BASE_W] == $past(base_q)));

  // R7
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_fire |=> $stable(vector));

  // R7
  isr_grow_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_fire |=> ((isr_q & ~$past(isr_q)) == '0));

  // R9
  aeoi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && aeoi_q) |=> !isr_q[vector[LVL_W-1:0]]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.VEC_W(VEC_W), .BASE_W(BASE_W)) i_chk (
  .clk(clk), .rst(rst), .int_out(int_out), .ack_fire(ack_fire), .vector(vector),
  .req_q(req_q), .isr_q(isr_q), .mask_q(mask_q), .aeoi_q(aeoi_q), .base_q(base_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       ack = 1'b0;
  logic       int_out;
  logic [7:0] vector;

  int total = 0;
  int bad = 0;
  int base = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ack(ack), .int_out(int_out), .vector(vector)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse(input int ln);
    @(negedge clk); irq_in[ln] = 1'b1;
    @(negedge clk); irq_in[ln] = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic eoi_top();
    wr(2'd2, 8'h08);
  endtask

  task automatic eoi_lvl(input int l);
    wr(2'd2, 8'(8'h18 | l));
  endtask

  function automatic int vexp(input int l);
    return base * 8 + l;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 int_out after reset", int_out, 0);
    chk("R1 vector after reset", vector, 0);

    // R3: all lines masked out of reset; request stays latched
    pulse(3);
    chk("R3 masked line no interrupt", int_out, 0);
    wr(2'd0, 8'h00);
    chk("R3 unmask exposes pending", int_out, 1);
    do_ack();
    chk("R6 vector level 3", vector, vexp(3));
    eoi_top();
    chk("R10 close leaves idle", int_out, 0);

    // R4/R5/R10 sweep over every ordered pair of lines
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        pulse(i);
        chk("R2 edge raises int", int_out, 1);
        do_ack();
        chk("R6 vector first", vector, vexp(i));
        chk("R6 request consumed", int_out, 0);
        pulse(j);
        chk("R5 nesting", int_out, (j < i) ? 1 : 0);
        if (j < i) begin
          do_ack();
          chk("R6 nested vector", vector, vexp(j));
          eoi_top();
          pulse(j);
          chk("R10 nonspecific closes top level", int_out, 1);
          do_ack();
          chk("R4 nested again", vector, vexp(j));
          eoi_top();
          eoi_top();
        end else begin
          eoi_top();
          chk("R10 release blocked", int_out, 1);
          do_ack();
          chk("R6 vector after release", vector, vexp(j));
          eoi_top();
        end
        chk("R10 all closed", int_out, 0);
      end
    end

    // R4 with masking: line 1 masked, line 6 wins
    wr(2'd0, 8'h02);
    pulse(1); pulse(6);
    do_ack();
    chk("R4 masked higher skipped", vector, vexp(6));
    eoi_top();
    wr(2'd0, 8'h00);
    chk("R3 masked request still pending", int_out, 1);
    do_ack();
    chk("R3 masked request served", vector, vexp(1));
    eoi_top();

    // R11 specific close
    pulse(5); do_ack(); pulse(2); do_ack();
    chk("R6 vector 2 over 5", vector, vexp(2));
    eoi_lvl(5);
    pulse(4);
    chk("R11 specific keeps level 2", int_out, 0);
    eoi_lvl(2);
    chk("R11 specific releases 4", int_out, 1);
    do_ack(); eoi_lvl(4);
    chk("R11 all closed", int_out, 0);

    // R11 unset level and idle opcodes
    pulse(3); do_ack();
    eoi_lvl(6);
    wr(2'd2, 8'h03);
    wr(2'd2, 8'h13);
    pulse(5);
    chk("R11 no-op commands keep level 3", int_out, 0);
    eoi_lvl(3);
    chk("R11 close 3 releases 5", int_out, 1);
    do_ack(); eoi_top();

    // R7 acknowledge with nothing raised
    do_ack();
    chk("R7 stray ack keeps vector", vector, vexp(5));
    chk("R7 stray ack no interrupt", int_out, 0);
    pulse(6);
    chk("R7 no in-service from stray ack", int_out, 1);
    do_ack(); eoi_top();

    // R2 held line gives one request
    @(negedge clk); irq_in[2] = 1'b1;
    @(negedge clk);
    do_ack();
    chk("R2 held line vector", vector, vexp(2));
    eoi_top();
    repeat (3) @(negedge clk);
    chk("R2 held line no repeat", int_out, 0);
    irq_in[2] = 1'b0;

    // R8 base change
    wr(2'd1, 8'hD0);
    base = 8'hD0 >> 3;
    pulse(1); do_ack();
    chk("R8 new base vector", vector, 8'hD1);
    eoi_top();

    // R9 automatic end-of-interrupt
    wr(2'd1, 8'hD1);
    pulse(4); do_ack();
    chk("R9 vector", vector, vexp(4));
    pulse(6);
    chk("R9 lower level not blocked", int_out, 1);
    do_ack();
    chk("R9 second vector", vector, vexp(6));
    pulse(6);
    chk("R9 equal level not blocked", int_out, 1);
    do_ack();
    wr(2'd1, 8'hD0);
    pulse(7); do_ack();
    pulse(7);
    chk("R8 auto close off again", int_out, 0);
    eoi_top();
    do_ack(); eoi_top();

    // R1 reset mid-service
    pulse(0); do_ack();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 reset vector", vector, 0);
    chk("R1 reset int", int_out, 0);
    pulse(4);
    chk("R1 reset remasks", int_out, 0);
    wr(2'd0, 8'h00);
    do_ack();
    chk("R1 reset base zero", vector, 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule